// File: doc/BRIEF.md
# Dual-Register Edge Input Capture

This block watches an external pin and, when a chosen kind of transition shows up, copies the value of a free-running timer count into one of two capture registers. The pin is brought into the clock domain by a synchronizer chain. The block keeps the last synchronized level so that it can tell a rising transition from a falling one. The timer count comes in as a plain input vector. The counter itself and any register access sit outside this block.

Each arming allows at most two captures. The first qualifying transition fills slot one and the second fills slot two. After that, transitions are dropped until the unit is armed again. Two things re-arm it: a clear strobe, which software pulses when it clears its capture status, or the capture mode moving from off to any active mode. A select input chooses whether the one-cycle capture event is raised on the first capture or on the second. That event is meant to feed an interrupt status bit.

Top module: `edge_capture_unit`

## Requirements
- R1: The 2-bit `mode_i` selects the qualifying transitions: 0 = off (no transition qualifies), 1 = low-to-high only, 2 = high-to-low only, 3 = either direction.
- R2: A capture is taken only while `pin_is_input_i` is 1. Transitions seen while it is 0 leave both capture registers, the capture event and the capture count unchanged.
- R3: After arming, the first qualifying transition loads `cap1_o` and the second loads `cap2_o`. Any later transitions leave both registers unchanged until the unit is re-armed.
- R4: `cap_evt_o` is high for exactly one cycle. It is raised when the first capture is taken if `second_sel_i` is 0, and when the second capture is taken if `second_sel_i` is 1. It is never raised at any other time.
- R5: A 1 on `clr_i` in a cycle resets the capture count to zero, so the next transition loads `cap1_o` again. A qualifying transition in that same cycle is discarded.
- R6: A cycle in which `mode_i` is nonzero while the mode seen in the previous cycle was 0 re-arms the unit in the same way as `clr_i`.
- R7: While `rst` is high, `cap1_o`, `cap2_o` and `cap_evt_o` are zero, the capture count is zero, and the synchronizer and the stored previous level are zero.
- R8: If `pin_i` changes level and is sampled at rising edge k, the capture registers and the event update at edge k+2, and they store the `count_i` value present at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Asynchronous external capture pin |
| count_i | input | CNT_W | Live timer count |
| mode_i | input | 2 | Qualifying transition mode |
| pin_is_input_i | input | 1 | Pin direction, 1 = input (capture allowed) |
| second_sel_i | input | 1 | 0 = event on first capture, 1 = event on second capture |
| clr_i | input | 1 | Re-arm strobe (resets the capture count) |
| cap1_o | output | CNT_W | First capture register |
| cap2_o | output | CNT_W | Second capture register |
| cap_evt_o | output | 1 | One-cycle capture event |

## Verification
A pin transition takes two synchronizer flops and one capture register to reach the outputs. A level driven before edge k therefore shows in `cap1_o`, `cap2_o` and `cap_evt_o` just after edge k+2, together with the count present at k+2. A re-arm strobe or a mode enable changes the count at the same edge it is sampled. The bench drives inputs on falling edges and steps its behavioural model at each rising edge, reading the same input values. It compares all three outputs one nanosecond after every rising edge, so each result is checked in the cycle the model says it is due. The sequences cover every mode, the direction gate, the third and later transitions, both select settings, and a re-arm landing on the same cycle as a transition.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    CAP_OFF  = 2'd0,
    CAP_RISE = 2'd1,
    CAP_FALL = 2'd2,
    CAP_BOTH = 2'd3
  } cap_mode_e;

  localparam int CAP_SLOTS = 2;
  localparam int SLOT_W    = $clog2(CAP_SLOTS + 1);
endpackage

// File: rtl/cap_pin_sync.sv
module cap_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic lvl_o,
  output logic prev_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= pin_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign prev_o = prev_q;

  AST_PREV_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (prev_q == $past(chain_q[STAGES-1]))); // R8
endmodule

// File: rtl/cap_edge_qual.sv
module cap_edge_qual
  import cap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lvl_i,
  input  logic       prev_i,
  input  logic [1:0] mode_i,
  input  logic       pin_is_input_i,
  output logic       hit_o,
  output logic       arm_o
);
  cap_mode_e mode;
  logic      mode_off_q;
  logic      rise, fall, sel_edge;

  assign mode = cap_mode_e'(mode_i);
  assign rise = lvl_i & ~prev_i;
  assign fall = ~lvl_i & prev_i;

  always_comb begin
    unique case (mode)
      CAP_RISE: sel_edge = rise;
      CAP_FALL: sel_edge = fall;
      CAP_BOTH: sel_edge = rise | fall;
      default:  sel_edge = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mode_off_q <= 1'b1;
    else     mode_off_q <= (mode == CAP_OFF);
  end

  assign hit_o = sel_edge & pin_is_input_i;
  assign arm_o = mode_off_q & (mode != CAP_OFF);

  AST_HIT_NEEDS_DIR: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> pin_is_input_i); // R2
  AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd0) |-> !hit_o); // R1
endmodule

// File: rtl/cap_store.sv
module cap_store
  import cap_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_i,
  input  logic             rearm_i,
  input  logic             second_sel_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] cap1_o,
  output logic [CNT_W-1:0] cap2_o,
  output logic             evt_o
);
  logic [SLOT_W-1:0] slot_q;
  logic [CNT_W-1:0]  cap1_q, cap2_q;
  logic              evt_q;
  logic              take;
  logic [SLOT_W-1:0] sel_slot;

  assign take     = hit_i & ~rearm_i & (slot_q < SLOT_W'(CAP_SLOTS));
  assign sel_slot = SLOT_W'(second_sel_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
      cap1_q <= '0;
      cap2_q <= '0;
      evt_q  <= 1'b0;
    end else begin
      evt_q <= take & (slot_q == sel_slot);
      if (rearm_i) begin
        slot_q <= '0;
      end else if (take) begin
        slot_q <= slot_q + 1'b1;
        if (slot_q == '0) cap1_q <= count_i;
        else              cap2_q <= count_i;
      end
    end
  end

  assign cap1_o = cap1_q;
  assign cap2_o = cap2_q;
  assign evt_o  = evt_q;

  AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (rst)
    slot_q <= SLOT_W'(CAP_SLOTS)); // R3
  AST_CAP1_HOLD: assert property (@(posedge clk) disable iff (rst)
    (slot_q != '0 && !rearm_i) |=> $stable(cap1_q)); // R3
  AST_CAP2_HOLD: assert property (@(posedge clk) disable iff (rst)
    (slot_q == SLOT_W'(CAP_SLOTS) && !rearm_i) |=> $stable(cap2_q)); // R3
  AST_REARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
    rearm_i |=> (slot_q == '0) && !evt_q); // R5
  AST_EVT_PULSE: assert property (@(posedge clk) disable iff (rst)
    evt_q |=> !evt_q || $past(hit_i)); // R4
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit #(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [1:0]       mode_i,
  input  logic             pin_is_input_i,
  input  logic             second_sel_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cap1_o,
  output logic [CNT_W-1:0] cap2_o,
  output logic             cap_evt_o
);
  logic lvl, prev_lvl, hit, arm, rearm;

  cap_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i(pin_i), .lvl_o(lvl), .prev_o(prev_lvl)
  );

  cap_edge_qual u_qual (
    .clk(clk), .rst(rst), .lvl_i(lvl), .prev_i(prev_lvl), .mode_i(mode_i),
    .pin_is_input_i(pin_is_input_i), .hit_o(hit), .arm_o(arm)
  );

  assign rearm = clr_i | arm;

  cap_store #(.CNT_W(CNT_W)) u_store (
    .clk(clk), .rst(rst), .hit_i(hit), .rearm_i(rearm),
    .second_sel_i(second_sel_i), .count_i(count_i),
    .cap1_o(cap1_o), .cap2_o(cap2_o), .evt_o(cap_evt_o)
  );

  AST_EVT_DIR: assert property (@(posedge clk) disable iff (rst)
    cap_evt_o |-> $past(pin_is_input_i)); // R2
endmodule

// File: tb/edge_capture_unit_bench.sv
`timescale 1ns/100ps
module edge_capture_unit_bench;
  localparam int W = 32;
  logic         clk = 0, rst = 1, pin = 0, dir = 0, sel = 0, clr = 0;
  logic [W-1:0] cnt = 0;
  logic [1:0]   mode = 0;
  logic [W-1:0] cap1, cap2;
  logic         evt;

  int n_chk = 0, n_bad = 0;
  string tag = "R7";

  // behavioural reference state
  bit           m_s1, m_s2, m_prev, m_evt;
  int           m_slots, m_mode_prev;
  logic [W-1:0] m_c1, m_c2;

  always #2.5 clk = ~clk;

  edge_capture_unit #(.CNT_W(W)) u_edge_capture_unit (
    .clk(clk), .rst(rst), .pin_i(pin), .count_i(cnt), .mode_i(mode),
    .pin_is_input_i(dir), .second_sel_i(sel), .clr_i(clr),
    .cap1_o(cap1), .cap2_o(cap2), .cap_evt_o(evt)
  );

  task automatic model_step();
    bit hit, re, rise, fall;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_evt = 0;
      m_slots = 0; m_mode_prev = 0; m_c1 = 0; m_c2 = 0;
      return;
    end
    rise = m_s2 && !m_prev;
    fall = !m_s2 && m_prev;
    // R1 encoding, R2 gating
    hit  = dir && ((mode == 1 && rise) || (mode == 2 && fall) || (mode == 3 && (rise || fall)));
    re   = clr || (m_mode_prev == 0 && mode != 0); // R5 R6
    m_evt = 0;
    if (re) m_slots = 0;
    else if (hit && m_slots < 2) begin // R3, R8: count at this edge
      if (m_slots == 0) m_c1 = cnt; else m_c2 = cnt;
      if (m_slots == int'(sel)) m_evt = 1; // R4
      m_slots++;
    end
    m_prev = m_s2; m_s2 = m_s1; m_s1 = pin; m_mode_prev = mode;
  endtask

  task automatic compare();
    n_chk++;
    if (cap1 !== m_c1 || cap2 !== m_c2 || evt !== m_evt) begin
      n_bad++;
      $display("FAIL %s t=%0t cap1=%h/%h cap2=%h/%h evt=%b/%b (actual/expected)",
               tag, $time, cap1, m_c1, cap2, m_c2, evt, m_evt);
    end
  endtask

  task automatic cyc(input bit p, input bit c = 0);
    @(negedge clk);
    pin = p; clr = c; cnt = cnt + 7;
    @(posedge clk);
    model_step();
    #1 compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(pin);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tag = "R7";
    idle(3);
    @(negedge clk); rst = 0;
    idle(1);
    // R1 R3 R4 R8: rising only, event on first capture
    tag = "R1_R3_R4_R8_rise";
    @(negedge clk); mode = 1; dir = 1; sel = 0;
    idle(2);
    cyc(1); idle(4); cyc(0); idle(4);
    cyc(1); idle(4); cyc(0); idle(4);
    cyc(1); idle(4); cyc(0); idle(4);   // third edge ignored (R3)
    // R5: clear re-arms, falling only, event on second
    tag = "R5_R1_R4_fall";
    @(negedge clk); mode = 2; sel = 1;
    cyc(pin, 1); idle(2);
    cyc(1); idle(4); cyc(0); idle(4);
    cyc(1); idle(4); cyc(0); idle(4);
    cyc(1); idle(4); cyc(0); idle(4);
    // R1 both edges
    tag = "R1_both";
    @(negedge clk); mode = 3; sel = 0;
    cyc(pin, 1); idle(2);
    cyc(1); idle(3); cyc(0); idle(4); cyc(1); idle(4);
    // R2: direction output, edges ignored
    tag = "R2_dir";
    cyc(pin, 1);
    @(negedge clk); dir = 0;
    cyc(0); idle(4); cyc(1); idle(4); cyc(0); idle(4);
    // R1: mode off ignores edges
    tag = "R1_off";
    @(negedge clk); dir = 1; mode = 0;
    cyc(1); idle(4); cyc(0); idle(4);
    // R6: enabling mode re-arms without clear (first fill slots, then re-enable)
    tag = "R6_arm";
    @(negedge clk); mode = 3;
    idle(1);
    cyc(1); idle(3); cyc(0); idle(3); cyc(1); idle(4);
    @(negedge clk); mode = 0;
    idle(2);
    @(negedge clk); mode = 1;
    idle(2);
    cyc(0); idle(3); cyc(1); idle(4);
    // R5: clear on the same cycle the edge is taken -> discarded
    tag = "R5_same_cycle";
    cyc(0, 1); idle(3);
    cyc(1); idle(1); cyc(1, 1); idle(4);
    cyc(0); idle(3); cyc(1); idle(4);
    // R4: back-to-back edges one cycle apart
    tag = "R4_fast";
    @(negedge clk); mode = 3; sel = 1;
    cyc(pin, 1);
    cyc(0); cyc(1); cyc(0); idle(5);
    // R7: reset again clears outputs
    tag = "R7_reset";
    @(negedge clk); rst = 1;
    idle(3);
    @(negedge clk); rst = 0; pin = 0;
    idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule